// File: doc/BRIEF.md
# MDIO Clause-22 Management Master

This block carries register reads and writes from a host to an external Ethernet PHY over the two-wire management bus. The bus has a clock line, MDC, and a single shared data line, MDIO. The host presents one command at a time. A command holds a read/write flag, a 5-bit PHY address, a 5-bit register address and, for a write, a 16-bit data word. The host may present it only while the block reports idle. The block then sends one complete 64-bit Clause-22 frame. For a read, it returns the sixteen bits the PHY sent back.

MDC is the system clock divided by a whole number. The divisor is set at elaboration from the system clock frequency parameter, using a fixed threshold table:

| System clock up to | Divisor |
|---|---|
| 20 MHz | 8 |
| 40 MHz | 16 |
| 80 MHz | 32 |
| 120 MHz | 48 |
| 160 MHz | 64 |
| 240 MHz | 96 |

A frequency above 240 MHz has no entry, and elaboration stops with a fatal message. MDIO is driven on the falling edge of MDC and read on the rising edge. A separate output enable lets the pad release the line, so the PHY can drive it during the turnaround and data bits of a read.

Top module: `mdio_master`

## Requirements
- R1: Each MDIO bit lasts DIV system-clock cycles, where DIV is the divisor picked from the table. MDC is high for the last DIV/2 cycles of each bit, and a frame has exactly 64 MDC rising edges.
- R2: Every frame starts with 32 one bits, followed by the start pattern 0 then 1.
- R3: After the start pattern come two opcode bits: 0,1 for a write and 1,0 for a read.
- R4: After the opcode come the 5-bit PHY address and then the 5-bit register address, each sent most significant bit first.
- R5: In a write, frame bits 46 and 47 (counting from 0 at the first preamble bit) carry 1 then 0. Bits 48 to 63 carry the write data, most significant bit first. The output enable stays high for all 64 bits.
- R6: In a read, the output enable is low for frame bits 46 to 63 and high for bits 0 to 45. Whenever the block is idle, the output enable is low.
- R7: While a frame is in progress, mdio_o changes only in the cycle where MDC falls, so it is stable for the whole high phase of MDC.
- R8: idle is 1 after reset. It goes low on the clock edge that accepts a command and stays low for exactly 64*DIV cycles.
- R9: Commands presented while idle is low are ignored and do not change the frame in progress. A command that is valid in a cycle where idle is high is accepted on that edge, including the first idle cycle after a frame ends.
- R10: rd_data is 0 after reset. At the end of a read, rd_data takes the 16 mdio_i values sampled on the MDC rising edges of frame bits 48 to 63, the first sample becoming bit 15. Writes leave rd_data unchanged, and rd_data holds its value while idle.
- R11: MDC is low whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request; taken only while idle is high |
| cmd_read | input | 1 | 1 selects a read, 0 selects a write |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Data word for a write |
| idle | output | 1 | High when no frame is in progress |
| rd_data | output | 16 | Result of the last completed read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | 1 to drive MDIO, 0 to release it |
| mdio_i | input | 1 | Value read from MDIO |

## Verification
Two events can fall in the same cycle: a frame finishing and a new command arriving. To provoke this, the bench holds cmd_valid high through the whole frame, with different fields during the busy time. It then checks three things: idle is high for exactly one cycle, the first frame is unchanged, and the next frame carries the fields present at the idle cycle. The bench also pushes a conflicting command in the middle of a frame and compares the captured bits against the frame computed from the original command. Finally, it sweeps all 32 PHY addresses with writes and all 32 register addresses with reads, comparing every captured bit, every output-enable value and every returned word against values rebuilt arithmetically from the command.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned TA_FIRST   = 46;
  localparam int unsigned DATA_FIRST = 48;

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] START_PAT = 2'b01;
  localparam logic [1:0] TA_WRITE  = 2'b10;

  // Divisor from the system clock threshold table; 0 marks an illegal clock.
  function automatic int unsigned pick_mdc_div(input longint unsigned hz);
    if      (hz <=  20_000_000) return 8;
    else if (hz <=  40_000_000) return 16;
    else if (hz <=  80_000_000) return 32;
    else if (hz <= 120_000_000) return 48;
    else if (hz <= 160_000_000) return 64;
    else if (hz <= 240_000_000) return 96;
    else                        return 0;
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned CW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] MID  = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;

  always_comb begin
    rise_stb = run && (cnt_q == MID);
    fall_stb = run && (cnt_q == LAST);
    if (!run)          cnt_d = '0;
    else if (fall_stb) cnt_d = '0;
    else               cnt_d = cnt_q + CW'(1);
    if (!run)          mdc_d = 1'b0;
    else if (rise_stb) mdc_d = 1'b1;
    else if (fall_stb) mdc_d = 1'b0;
    else               mdc_d = mdc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        op_read,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  input  logic        rise_stb,
  input  logic        fall_stb,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rd_data
);
  localparam int unsigned BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
  localparam logic [BW-1:0] TA_BIT   = BW'(TA_FIRST);
  localparam logic [BW-1:0] DAT_BIT  = BW'(DATA_FIRST);

  logic                  busy_q, busy_d;
  logic                  rd_q, rd_d;
  logic [BW-1:0]         bit_q, bit_d;
  logic [FRAME_BITS-1:0] tx_q, tx_d;
  logic [15:0]           rx_q, rx_d;
  logic [15:0]           res_q, res_d;
  logic [FRAME_BITS-1:0] frame;
  logic                  take;

  always_comb begin
    frame = {32'hFFFF_FFFF, START_PAT, (op_read ? OP_READ : OP_WRITE),
             phy_addr, reg_addr,
             (op_read ? 2'b11 : TA_WRITE),
             (op_read ? 16'hFFFF : wr_data)};
    take   = start && !busy_q;
    busy_d = busy_q;
    rd_d   = rd_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    res_d  = res_q;
    if (take) begin
      busy_d = 1'b1;
      rd_d   = op_read;
      bit_d  = '0;
      tx_d   = frame;
    end else if (busy_q) begin
      if (rise_stb && rd_q && (bit_q >= DAT_BIT))
        rx_d = {rx_q[14:0], mdio_i};
      if (fall_stb) begin
        if (bit_q == LAST_BIT) begin
          busy_d = 1'b0;
          if (rd_q) res_d = rx_q;
        end else begin
          bit_d = bit_q + BW'(1);
          tx_d  = {tx_q[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      bit_q  <= '0;
      tx_q   <= '1;
      rx_q   <= '0;
      res_q  <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      res_q  <= res_d;
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = busy_q ? tx_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe = busy_q && !(rd_q && (bit_q >= TA_BIT));
  assign rd_data = res_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter longint unsigned SYS_CLK_HZ = 125_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_read,
  input  logic [4:0]  cmd_phy,
  input  logic [4:0]  cmd_reg,
  input  logic [15:0] cmd_wdata,
  output logic        idle,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int unsigned DIV = pick_mdc_div(SYS_CLK_HZ);

  generate
    if (DIV == 0) begin : g_bad_clk
      $fatal(1, "system clock above 240 MHz has no MDC divisor");
    end
  endgenerate

  // Reset asserts at once and leaves on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic busy, rise_stb, fall_stb;

  mdio_mdc_gen #(.DIV((DIV == 0) ? 8 : DIV)) u_mdc (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (busy),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (cmd_valid),
    .op_read  (cmd_read),
    .phy_addr (cmd_phy),
    .reg_addr (cmd_reg),
    .wr_data  (cmd_wdata),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_data  (rd_data)
  );

  assign idle = !busy;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
#(
  parameter longint unsigned SYS_CLK_HZ = 125_000_000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        idle,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [15:0] rd_data
);
  localparam int unsigned DIV = pick_mdc_div(SYS_CLK_HZ);
  localparam int unsigned FRAME_CYC = FRAME_BITS * DIV;

  int unsigned low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    low_cnt <= 0;
    else if (idle) low_cnt <= 0;
    else           low_cnt <= low_cnt + 1;
  end

  assert_mdc_low_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mdc);

  assert_release_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> !idle);

  assert_change_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !$past(idle) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));

  assert_frame_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> (low_cnt == FRAME_CYC));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && $past(idle)) |-> $stable(rd_data));
endmodule

bind mdio_master mdio_master_chk #(.SYS_CLK_HZ(SYS_CLK_HZ)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .idle    (idle),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe),
  .rd_data (rd_data)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam longint unsigned CLK_HZ = 20_000_000;
  localparam int DIV = 8;
  localparam int FRAME_CYC = 64 * DIV;
  localparam logic [63:0] RD_MASK = 64'hFFFF_FFFF_FFFC_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_read = 1'b0, mdio_i = 1'b1;
  logic [4:0] cmd_phy = '0, cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic idle, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;

  int nchecks = 0, nerr = 0;
  logic [15:0] last_rd = '0;

  always #4 clk = ~clk;

  mdio_master #(.SYS_CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .idle(idle), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, wd};
  endfunction

  // Records one frame at negedges until idle returns; also plays the PHY.
  task automatic capture(input logic [15:0] resp, output logic [63:0] bits,
                         output logic [63:0] oes, output int lowcyc,
                         output int rises, output int unstable, output int badhigh);
    logic prev_mdc;
    logic cur;
    int hi;
    bits = '0; oes = '0; lowcyc = 0; rises = 0; unstable = 0; badhigh = 0;
    prev_mdc = 1'b0; cur = 1'b1; hi = 0;
    while (idle == 1'b0 && lowcyc < 2 * FRAME_CYC) begin
      if (mdc && !prev_mdc) begin
        if (rises < 64) begin
          bits[63 - rises] = mdio_o;
          oes[63 - rises]  = mdio_oe;
        end
        cur = mdio_o;
        rises++;
        hi = 0;
      end
      if (mdc) begin
        hi++;
        if (mdio_o !== cur) unstable++;
      end
      if (!mdc && prev_mdc && hi != DIV / 2) badhigh++;
      if (!mdc) mdio_i = (rises >= 48 && rises <= 63) ? resp[63 - rises] : 1'b1;
      prev_mdc = mdc;
      lowcyc++;
      @(negedge clk);
    end
    if (hi != DIV / 2) badhigh++;
    mdio_i = 1'b1;
  endtask

  task automatic issue(input logic rd, input logic [4:0] phy,
                       input logic [4:0] rg, input logic [15:0] wd);
    @(negedge clk);
    while (!idle) @(negedge clk);
    cmd_valid = 1'b1; cmd_read = rd; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(idle == 1'b0, "R8 idle drops on accept", idle, 0);
  endtask

  task automatic judge(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd, input logic [15:0] resp,
                       input logic [63:0] bits, input logic [63:0] oes, input int lowcyc,
                       input int rises, input int unstable, input int badhigh);
    logic [63:0] e;
    e = exp_frame(rd, phy, rg, wd);
    check(lowcyc == FRAME_CYC, "R8 idle low length", lowcyc, FRAME_CYC);
    check(rises == 64 && badhigh == 0, "R1 mdc shape", rises, 64);
    check(bits[63:30] == e[63:30], "R2 preamble and start", bits[63:30], e[63:30]);
    check(bits[29:28] == e[29:28], "R3 opcode", bits[29:28], e[29:28]);
    check(bits[27:18] == e[27:18], "R4 addresses", bits[27:18], e[27:18]);
    check(unstable == 0, "R7 stable while mdc high", unstable, 0);
    if (rd) begin
      check(oes == RD_MASK, "R6 read release", oes, RD_MASK);
      @(negedge clk);
      check(rd_data == resp, "R10 read result", rd_data, resp);
      last_rd = resp;
    end else begin
      check(bits[17:0] == e[17:0], "R5 turnaround and data", bits[17:0], e[17:0]);
      check(oes == '1, "R5 drive all bits", oes, 64'hFFFF_FFFF_FFFF_FFFF);
      @(negedge clk);
      check(rd_data == last_rd, "R10 write keeps result", rd_data, last_rd);
    end
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R11 R6 idle lines", {mdc, mdio_oe}, 0);
  endtask

  initial begin : watchdog
    repeat (150_000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchecks + 1);
    $finish;
  end

  initial begin : main
    logic [63:0] bits, oes;
    int lowcyc, rises, unstable, badhigh;
    repeat (3) @(negedge clk);
    check(idle == 1'b1 && mdc == 1'b0 && mdio_oe == 1'b0, "R8 R11 reset state",
          {idle, mdc, mdio_oe}, 3'b100);
    check(rd_data == 16'h0, "R10 reset result", rd_data, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // write sweep over every PHY address
    for (int p = 0; p < 32; p++) begin
      logic [4:0] rg;
      logic [15:0] wd;
      rg = 5'(31 - p);
      wd = 16'({p[4:0], rg, 6'b101101}) ^ 16'(p * 16'h0A53);
      issue(1'b0, 5'(p), rg, wd);
      capture(16'h0, bits, oes, lowcyc, rises, unstable, badhigh);
      judge(1'b0, 5'(p), rg, wd, 16'h0, bits, oes, lowcyc, rises, unstable, badhigh);
    end

    // read sweep over every register address
    for (int r = 0; r < 32; r++) begin
      logic [4:0] ph;
      logic [15:0] resp;
      ph = 5'(r) ^ 5'h15;
      resp = 16'(r * 16'h1F3B) ^ 16'hC35A;
      issue(1'b1, ph, 5'(r), 16'h0);
      capture(resp, bits, oes, lowcyc, rises, unstable, badhigh);
      judge(1'b1, ph, 5'(r), 16'h0, resp, bits, oes, lowcyc, rises, unstable, badhigh);
    end

    // R9: a command pushed mid-frame is ignored
    issue(1'b0, 5'h0A, 5'h11, 16'hBEEF);
    fork
      capture(16'h0, bits, oes, lowcyc, rises, unstable, badhigh);
      begin
        repeat (100) @(negedge clk);
        cmd_valid = 1'b1; cmd_read = 1'b1; cmd_phy = 5'h1F; cmd_reg = 5'h00;
        cmd_wdata = 16'h0000;
        repeat (50) @(negedge clk);
        cmd_valid = 1'b0;
      end
    join
    check(bits == exp_frame(1'b0, 5'h0A, 5'h11, 16'hBEEF), "R9 busy command ignored",
          bits, exp_frame(1'b0, 5'h0A, 5'h11, 16'hBEEF));
    judge(1'b0, 5'h0A, 5'h11, 16'hBEEF, 16'h0, bits, oes, lowcyc, rises, unstable, badhigh);

    // R9: command held across frame end is taken in the single idle cycle
    @(negedge clk);
    cmd_valid = 1'b1; cmd_read = 1'b0; cmd_phy = 5'h03; cmd_reg = 5'h1C; cmd_wdata = 16'h5A0F;
    @(negedge clk);
    cmd_read = 1'b1; cmd_phy = 5'h16; cmd_reg = 5'h09; cmd_wdata = 16'h0;
    capture(16'h0, bits, oes, lowcyc, rises, unstable, badhigh);
    check(bits == exp_frame(1'b0, 5'h03, 5'h1C, 16'h5A0F), "R9 first of back-to-back",
          bits, exp_frame(1'b0, 5'h03, 5'h1C, 16'h5A0F));
    check(idle == 1'b1, "R9 idle visible one cycle", idle, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(idle == 1'b0, "R9 next command taken at once", idle, 0);
    capture(16'h9C31, bits, oes, lowcyc, rises, unstable, badhigh);
    judge(1'b1, 5'h16, 5'h09, 16'h0, 16'h9C31, bits, oes, lowcyc, rises, unstable, badhigh);

    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end
endmodule